// File: doc/BRIEF.md
# Real-Time Clock Write-Protection and Init Handshake Controller

This block guards the configuration registers of a real-time clock. Software must write two key bytes in a fixed order to a key register before any protected register accepts a write. A single lock byte, or any key write that breaks the order, closes access again. Once access is open, software sets an init-request bit in the control register. The block passes that request through a two-stage chain that is clocked by the slow counting tick. When the request reaches the end of the chain, an init-acknowledge output rises and the counter-enable output falls, so the counting logic is frozen.

Time, date and prescaler values are written only while access is open and init mode is acknowledged. When software clears the request, the acknowledge falls after the same two-tick delay. On the next tick where neither the request nor the acknowledge is set, the readable shadow copies of time and date are loaded and a registers-synchronized flag rises. Software polls that flag before reading back the new values.

Top module: `rtc_wprot_ctrl`

## Requirements
- R1: Key writes go to address 0, and only bits 7:0 are compared. A key write of 0xCA followed by a key write of 0x53 sets `unlocked` on the clock edge that takes the second write. Writes to other addresses in between do not disturb the sequence.
- R2: A key write of 0xFF clears `unlocked` on the next edge.
- R3: A key write of 0xCA always starts the sequence over as its first step. Any other key write that is not the expected next byte leaves the block locked, and no partial progress is kept. This includes a second 0x53, and any byte other than 0xCA written while unlocked.
- R4: While locked, writes to the control register (address 1), time (address 2), date (address 3) and prescaler (address 4) are dropped and leave their contents unchanged.
- R5: The init request is bit 0 of the control register. Each `slow_tick` moves the request one step along a two-stage chain. `init_ack` rises on the second tick edge after the request register holds 1.
- R6: After the request is cleared, `init_ack` falls on the second tick edge. `count_en` is high exactly when `init_ack` is low.
- R7: Writes to time, date and prescaler take effect only when `unlocked` and `init_ack` are both high. Otherwise they are dropped.
- R8: On a tick edge where both the request and `init_ack` are low, `time_shadow` and `date_shadow` load the time and date registers and `regs_synced` is set. The prescaler value is visible at once on `presc_q`, and its reset value is 0x007F00FF.
- R9: An accepted control write with bit 0 set clears `regs_synced` on the next edge. The clear takes priority over a set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse marking each edge of the slow counting clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| unlocked | output | 1 | Protected registers writable |
| init_ack | output | 1 | Init mode acknowledged, counters frozen |
| regs_synced | output | 1 | Shadow copies hold current time and date |
| count_en | output | 1 | Counting logic enabled |
| time_shadow | output | 32 | Readable copy of the time register |
| date_shadow | output | 32 | Readable copy of the date register |
| presc_q | output | 32 | Prescaler register |

## Verification
The assertions assume that `slow_tick` is a single-cycle pulse. They also assume that the bus issues at most one write per cycle, with address and data valid whenever `wr_en` is high. The bench drives every write for exactly one cycle. It spaces tick pulses with idle cycles between them and never drives an unused address. Some tick pulses fall in the same cycle as a control write, which exercises the priority of the clear over the set.

// File: rtl/rtc_wprot_ctrl.sv
module rtc_wprot_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [7:0] KEY_FIRST = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53,
  parameter logic [7:0] KEY_CLOSE = 8'hFF,
  parameter logic [DATA_W-1:0] PRESC_RST = 32'h007F00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked,
  output logic              init_ack,
  output logic              regs_synced,
  output logic              count_en,
  output logic [DATA_W-1:0] time_shadow,
  output logic [DATA_W-1:0] date_shadow,
  output logic [DATA_W-1:0] presc_q
);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(4);

  typedef enum logic [1:0] {K_LOCKED, K_HALF, K_OPEN} key_st_t;

  key_st_t key_st, key_nx;
  logic init_req, req_s1, req_s2;
  logic [DATA_W-1:0] time_r, date_r;

  wire key_wr   = wr_en && wr_addr == A_KEY;
  wire ctrl_wr  = wr_en && wr_addr == A_CTRL && unlocked;
  wire cfg_ok   = unlocked && req_s2;
  wire time_wr  = wr_en && wr_addr == A_TIME && cfg_ok;
  wire date_wr  = wr_en && wr_addr == A_DATE && cfg_ok;
  wire presc_wr = wr_en && wr_addr == A_PRESC && cfg_ok;
  wire sync_now = slow_tick && !init_req && !req_s2;

  assign unlocked = key_st == K_OPEN;
  assign init_ack = req_s2;
  assign count_en = !req_s2;

  always_comb begin
    key_nx = key_st;
    if (key_wr) begin
      if (wr_data[7:0] == KEY_FIRST)
        key_nx = K_HALF;
      else if (wr_data[7:0] == KEY_SECOND && key_st == K_HALF)
        key_nx = K_OPEN;
      else
        key_nx = K_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st      <= K_LOCKED;
      init_req    <= 1'b0;
      req_s1      <= 1'b0;
      req_s2      <= 1'b0;
      regs_synced <= 1'b0;
      time_r      <= '0;
      date_r      <= '0;
      time_shadow <= '0;
      date_shadow <= '0;
      presc_q     <= PRESC_RST;
    end else begin
      key_st <= key_nx;
      if (ctrl_wr) init_req <= wr_data[0];
      if (slow_tick) begin
        req_s1 <= init_req;
        req_s2 <= req_s1;
      end
      if (sync_now) begin
        time_shadow <= time_r;
        date_shadow <= date_r;
      end
      if (ctrl_wr && wr_data[0]) regs_synced <= 1'b0;
      else if (sync_now) regs_synced <= 1'b1;
      if (time_wr) time_r <= wr_data;
      if (date_wr) date_r <= wr_data;
      if (presc_wr) presc_q <= wr_data;
    end
  end
endmodule

module rtc_wprot_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              unlocked,
  input logic              init_ack,
  input logic              regs_synced,
  input logic [DATA_W-1:0] presc_q
);
  a_r1_unlock_after_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && wr_addr == ADDR_W'(0) && wr_data[7:0] == 8'h53));

  a_r2_close_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0) && wr_data[7:0] == 8'hFF) |=> !unlocked);

  a_r4_locked_presc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(presc_q));

  a_r5_ack_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(init_ack) |-> $past(slow_tick));

  a_r7_presc_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ack |=> $stable(presc_q));

  a_r8_sync_on_tick_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs_synced) |-> $past(slow_tick) && !init_ack);

  a_r9_init_request_clears_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked && wr_addr == ADDR_W'(1) && wr_data[0]) |=> !regs_synced);
endmodule

bind rtc_wprot_ctrl rtc_wprot_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .unlocked(unlocked), .init_ack(init_ack),
  .regs_synced(regs_synced), .presc_q(presc_q)
);

// File: tb/test_rtc_wprot_ctrl.sv
module test_rtc_wprot_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic unlocked, init_ack, regs_synced, count_en;
  logic [31:0] time_shadow, date_shadow, presc_q;

  always #5 clk = ~clk;

  rtc_wprot_ctrl i_rtc_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlocked(unlocked), .init_ack(init_ack), .regs_synced(regs_synced),
    .count_en(count_en), .time_shadow(time_shadow), .date_shadow(date_shadow),
    .presc_q(presc_q)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_key = 0;  // 0 locked, 1 first key seen, 2 open
  bit m_req = 0, m_p1 = 0, m_p2 = 0, m_sync = 0;
  logic [31:0] m_time = 0, m_date = 0, m_sht = 0, m_shd = 0, m_presc = 32'h007F00FF;

  always @(posedge clk) begin
    int k;
    bit rq, p1, p2;
    if (!rst_n) begin
      m_key = 0; m_req = 0; m_p1 = 0; m_p2 = 0; m_sync = 0;
      m_time = 0; m_date = 0; m_sht = 0; m_shd = 0; m_presc = 32'h007F00FF;
    end else begin
      k = m_key; rq = m_req; p1 = m_p1; p2 = m_p2;
      if (slow_tick) begin
        m_p1 = rq; m_p2 = p1;
        if (!rq && !p2) begin m_sht = m_time; m_shd = m_date; m_sync = 1; end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_key = (wr_data[7:0] == 8'hCA) ? 1 :
                        (wr_data[7:0] == 8'h53 && k == 1) ? 2 : 0;
          3'd1: if (k == 2) begin m_req = wr_data[0]; if (wr_data[0]) m_sync = 0; end
          3'd2: if (k == 2 && p2) m_time = wr_data;
          3'd3: if (k == 2 && p2) m_date = wr_data;
          3'd4: if (k == 2 && p2) m_presc = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      chk("R1/R2/R3 unlocked", 32'(unlocked), 32'(m_key == 2));
      chk("R5/R6 init_ack", 32'(init_ack), 32'(m_p2));
      chk("R6 count_en", 32'(count_en), 32'(!m_p2));
      chk("R8/R9 regs_synced", 32'(regs_synced), 32'(m_sync));
      chk("R4/R7/R8 time_shadow", time_shadow, m_sht);
      chk("R4/R7/R8 date_shadow", date_shadow, m_shd);
      chk("R4/R7 presc_q", presc_q, m_presc);
    end
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, bit tk = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; slow_tick = tk;
    @(negedge clk);
    wr_en = 0; slow_tick = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(2);                              // R8: sync rises outside init
    wr(3'd4, 32'h1234);                   // R4: locked, prescaler dropped
    wr(3'd1, 32'h1);                      // R4: locked, control dropped
    tick(3);                              // R5: no ack without request
    wr(3'd0, 32'h53);                     // R3: second key alone
    wr(3'd0, 32'hCA); wr(3'd0, 32'h12); wr(3'd0, 32'h53);  // R3: broken order
    wr(3'd0, 32'hCA); wr(3'd2, 32'h5); wr(3'd0, 32'h53);   // R1: other write between keys
    wr(3'd2, 32'h00112233);               // R7: outside init, dropped
    wr(3'd1, 32'h1, 1);                   // R9: request with tick in same cycle
    tick(1);
    wr(3'd3, 32'h00240315);               // R7: ack not yet high, dropped
    tick(1);                              // R5: ack rises here
    wr(3'd2, 32'h00235959);               // R7
    wr(3'd3, 32'h00991231);               // R7
    wr(3'd4, 32'h007C0127);               // R7
    tick(1);                              // R8: no sync while in init
    wr(3'd1, 32'h0);                      // R6
    tick(4);                              // R6, R8: ack falls, shadows load
    wr(3'd0, 32'hFF);                     // R2
    wr(3'd1, 32'h1);                      // R4: dropped while locked
    wr(3'd4, 32'hDEAD);                   // R4
    tick(3);
    wr(3'd0, 32'hCA); wr(3'd0, 32'hCA); wr(3'd0, 32'h53);  // R3: 0xCA restarts
    wr(3'd0, 32'h53);                     // R3: extra key while open locks
    wr(3'd0, 32'hCA); wr(3'd0, 32'h53);   // R1
    wr(3'd0, 32'h00);                     // R3
    tick(2);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule